// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer with Pinned Block Slots

This block is a small fully associative address translation buffer. Each entry maps a contiguous virtual range onto a physical base and carries a set of protection fields (reference trap, dirty, break, rights type, two privilege levels, an uncacheable flag and an access identifier). Ranges cover 4^n base pages rather than a single page. A combinational lookup port returns hit, the translated physical address, the start of the matching range and its protection fields. Rights checking is left to the consumer.

Entries are loaded by a wide insert that carries two 64-bit words, or by a two-step narrow insert (an address step followed by a protection step). They are removed by a range purge or by purge-all. The lowest `PINNED` slots form a reserved group of block entries. Only slot-addressed block insert and block purge commands write them, and ordinary purges and inserts leave them in place. Non-pinned slots are allocated from free slots first, then by a round-robin pointer.

Top module: `vpsize_tlb`

## Requirements
- R1: A lookup hits when `lk_va` lies between an entry's start and last address inclusive. When several valid entries match, the lowest-index one is returned. `lk_pa` is that entry's physical base plus (`lk_va` minus its start). On a miss every lookup output is zero.
- R2: Wide insert (op 1): n = `cmd_w1[3:0]`. The range size is 4 KB shifted left by 2n, and the virtual start is `cmd_addr` aligned down to that size. The physical base is `cmd_w1` shifted left by 7, aligned down to the same size and truncated to `PA_W` bits.
- R3: Wide insert fields come from `cmd_w2`: T bit 61, D bit 60, B bit 59, rights type bits 58:56, PL1 bits 55:54, PL2 bits 53:52, U bit 51, access ID bits 31:1.
- R4: Before a wide insert or a narrow address step is written, every valid non-pinned entry that overlaps the new range is invalidated. Pinned entries are not touched.
- R5: An insert into the non-pinned group takes the lowest-index free non-pinned slot. If none is free, it takes the slot under a round-robin pointer that advances only when it is used and wraps from the last slot to slot `PINNED`.
- R6: Range purge (op 4): n = `cmd_addr[3:0]`. The purge invalidates non-pinned entries overlapping 4^n pages from the page-aligned `cmd_addr`, so n = 0 purges a single page. Pinned entries survive.
- R7: Purge-all (op 5) invalidates every non-pinned entry, resets the round-robin pointer to slot `PINNED` and drops a pending narrow insert. Pinned entries survive.
- R8: Narrow address step (op 2) records a pending one-page range at the page-aligned `cmd_addr`, with physical page `cmd_w1[24:5]`. The protection step (op 3) writes an entry only if a range is pending and `cmd_addr` falls in it. Otherwise nothing is written and `cmd_err` is raised. Either way the pending range is consumed. Narrow protection fields come from `cmd_w2`: access ID 18:1, U 19, PL2 21:20, PL1 23:22, type 26:24, B 27, D 28, T 29.
- R9: Block insert (op 6) overwrites slot `cmd_slot` with the range of `cmd_len` pages at the page-aligned `cmd_addr`, physical page `cmd_w1`, and the narrow field layout with T forced to 0 and D forced to 1. Block purge (op 7) clears slot `cmd_slot`. A slot at or above `PINNED` changes nothing and raises `cmd_err`.
- R10: Each command (op 0 is a no-op) completes at the clock edge on which `cmd_valid` is sampled. A lookup in that same cycle sees the state before the command. `cmd_err` is valid for the one cycle after the command.
- R11: After a synchronous active-low reset, no entry is valid, no narrow insert is pending, `cmd_err` is 0 and the round-robin pointer is at slot `PINNED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | VA_W | Command virtual address |
| cmd_w1 | input | 64 | First command word |
| cmd_w2 | input | 64 | Second command word |
| cmd_slot | input | SLOT_W | Block slot index |
| cmd_len | input | LEN_W | Block length in pages |
| cmd_err | output | 1 | Command error, one cycle after the command |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_start | output | VA_W | Start of the matching range |
| lk_pa | output | PA_W | Translated physical address |
| lk_t | output | 1 | Reference trap flag |
| lk_d | output | 1 | Dirty flag |
| lk_b | output | 1 | Break flag |
| lk_rtype | output | 3 | Rights type |
| lk_pl1 | output | 2 | First privilege level |
| lk_pl2 | output | 2 | Second privilege level |
| lk_u | output | 1 | Uncacheable flag |
| lk_aid | output | 31 | Access identifier |

## Verification
A wrong valid bit, bound or physical base becomes visible on the lookup port in the first cycle after the faulty command, as a stale hit, a missing hit or a wrong `lk_pa`/`lk_start`. A wrong replacement pointer or free-slot choice stays hidden until the non-pinned group is full. It then shows as the wrong older page going missing on the next insert. The bench therefore fills the group completely before checking which page was evicted. Pending-state errors show on `cmd_err` in the cycle after the protection step.

// File: rtl/vpt_pkg.sv
// Shared types for the variable-page-size translation buffer.
// Assumes the command code and field layouts documented in the brief.
package vpt_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_WIDE_INS  = 3'd1,
        OP_NAR_ADDR  = 3'd2,
        OP_NAR_PROT  = 3'd3,
        OP_PURGE_RNG = 3'd4,
        OP_PURGE_ALL = 3'd5,
        OP_BLK_INS   = 3'd6,
        OP_BLK_PURGE = 3'd7
    } tlb_op_e;

    typedef struct packed {
        logic        t;
        logic        d;
        logic        b;
        logic [2:0]  rtype;
        logic [1:0]  pl1;
        logic [1:0]  pl2;
        logic        u;
        logic [30:0] aid;
    } tlb_prot_t;

    // Unpack protection fields from the wide-format second word.
    function automatic tlb_prot_t unpack_wide(input logic [63:0] w);
        tlb_prot_t p;
        p.t     = w[61];
        p.d     = w[60];
        p.b     = w[59];
        p.rtype = w[58:56];
        p.pl1   = w[55:54];
        p.pl2   = w[53:52];
        p.u     = w[51];
        p.aid   = w[31:1];
        return p;
    endfunction

    // Unpack protection fields from the narrow-format word.
    function automatic tlb_prot_t unpack_narrow(input logic [31:0] w);
        tlb_prot_t p;
        p.t     = w[29];
        p.d     = w[28];
        p.b     = w[27];
        p.rtype = w[26:24];
        p.pl1   = w[23:22];
        p.pl2   = w[21:20];
        p.u     = w[19];
        p.aid   = {13'd0, w[18:1]};
        return p;
    endfunction

endpackage

// File: rtl/vpt_lookup.sv
// Fully associative range match with lowest-index priority.
// Assumes start <= last for every valid entry.
module vpt_lookup #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 48,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [VA_W-1:0]               va,
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][VA_W-1:0]  lo,
    input  logic [ENTRIES-1:0][VA_W-1:0]  hi,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (va >= lo[g]) && (va <= hi[g]);
    end

    // Pick the lowest matching index.
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vpt_overlap.sv
// Computes which non-pinned entries a flush range or purge-all removes.
// Pinned slots (index below PINNED) are never selected.
module vpt_overlap #(
    parameter int ENTRIES = 16,
    parameter int PINNED  = 4,
    parameter int VA_W    = 48
) (
    input  logic                          rng_en,
    input  logic                          all_en,
    input  logic [VA_W-1:0]               rng_lo,
    input  logic [VA_W-1:0]               rng_hi,
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][VA_W-1:0]  lo,
    input  logic [ENTRIES-1:0][VA_W-1:0]  hi,
    output logic [ENTRIES-1:0]            kill
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
        if (g < PINNED) begin : g_pin
            assign kill[g] = 1'b0;
        end else begin : g_free
            assign kill[g] = vld[g] &&
                (all_en || (rng_en && (lo[g] <= rng_hi) && (rng_lo <= hi[g])));
        end
    end
endmodule

// File: rtl/vpt_victim.sv
// Chooses the slot for a non-pinned insert: lowest free slot, else the
// round-robin slot. Assumes rr already lies in [PINNED, ENTRIES-1].
module vpt_victim #(
    parameter int ENTRIES = 16,
    parameter int PINNED  = 4,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vld,
    input  logic [IDX_W-1:0]   rr,
    output logic [IDX_W-1:0]   slot,
    output logic               use_rr
);
    logic [ENTRIES-1:0] free;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_free
        if (g < PINNED) begin : g_pin
            assign free[g] = 1'b0;
        end else begin : g_open
            assign free[g] = !vld[g];
        end
    end

    // Lowest free slot wins; fall back to the round-robin pointer.
    always_comb begin
        use_rr = !(|free);
        slot   = rr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free[i]) slot = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vpt_cmd_decode.sv
// Decodes command words into ranges, physical bases and fields for each
// command kind. Purely combinational. Assumes PAGE_BITS >= 5 and
// PA_W <= VA_W <= 64.
module vpt_cmd_decode
    import vpt_pkg::*;
#(
    parameter int VA_W      = 48,
    parameter int PA_W      = 40,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 16
) (
    input  logic [VA_W-1:0]  addr,
    input  logic [63:0]      w1,
    input  logic [63:0]      w2,
    input  logic [LEN_W-1:0] len,
    output logic [VA_W-1:0]  wide_lo,
    output logic [VA_W-1:0]  wide_hi,
    output logic [PA_W-1:0]  wide_pa,
    output tlb_prot_t        wide_prot,
    output logic [VA_W-1:0]  purge_lo,
    output logic [VA_W-1:0]  purge_hi,
    output logic [VA_W-1:0]  page_lo,
    output logic [VA_W-1:0]  page_hi,
    output logic [PA_W-1:0]  nar_pa,
    output tlb_prot_t        nar_prot,
    output logic [VA_W-1:0]  blk_hi,
    output logic [PA_W-1:0]  blk_pa,
    output tlb_prot_t        blk_prot
);
    localparam logic [VA_W-1:0] PAGE_MASK = VA_W'((64'd1 << PAGE_BITS) - 64'd1);
    localparam int              PPN_SHIFT = PAGE_BITS - 5;

    logic [6:0]      wide_sh, purge_sh;
    logic [VA_W-1:0] wide_mask, purge_mask;
    logic [63:0]     w1_sh;

    // Size masks for the wide insert and range purge spans.
    always_comb begin
        wide_sh    = 7'(PAGE_BITS) + {2'b00, w1[3:0], 1'b0};
        purge_sh   = 7'(PAGE_BITS) + {2'b00, addr[3:0], 1'b0};
        wide_mask  = (VA_W'(1) << wide_sh) - VA_W'(1);
        purge_mask = (VA_W'(1) << purge_sh) - VA_W'(1);
    end

    // Wide insert range, physical base and fields.
    always_comb begin
        w1_sh     = w1 << PPN_SHIFT;
        wide_lo   = addr & ~wide_mask;
        wide_hi   = wide_lo | wide_mask;
        wide_pa   = w1_sh[PA_W-1:0] & ~wide_mask[PA_W-1:0];
        wide_prot = unpack_wide(w2);
    end

    // Single-page range, purge span and narrow fields.
    always_comb begin
        page_lo  = addr & ~PAGE_MASK;
        page_hi  = page_lo | PAGE_MASK;
        purge_lo = page_lo;
        purge_hi = page_lo + purge_mask;
        nar_pa   = PA_W'(w1[24:5]) << PAGE_BITS;
        nar_prot = unpack_narrow(w2[31:0]);
    end

    // Block range, base and forced flag values.
    always_comb begin
        blk_hi     = page_lo + (VA_W'(len) << PAGE_BITS) - VA_W'(1);
        blk_pa     = PA_W'(w1) << PAGE_BITS;
        blk_prot   = unpack_narrow(w2[31:0]);
        blk_prot.t = 1'b0;
        blk_prot.d = 1'b1;
    end
endmodule

// File: rtl/vpsize_tlb.sv
// Variable-page-size translation buffer with pinned block slots.
// Holds the entry store, pending narrow insert and replacement pointer;
// commands take effect at one clock edge, lookups are combinational on
// the registered state. Assumes 0 < PINNED < ENTRIES.
module vpsize_tlb
    import vpt_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int PINNED    = 4,
    parameter int VA_W      = 48,
    parameter int PA_W      = 40,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 16,
    parameter int SLOT_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [VA_W-1:0]   cmd_addr,
    input  logic [63:0]       cmd_w1,
    input  logic [63:0]       cmd_w2,
    input  logic [SLOT_W-1:0] cmd_slot,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_err,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [VA_W-1:0]   lk_start,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_t,
    output logic              lk_d,
    output logic              lk_b,
    output logic [2:0]        lk_rtype,
    output logic [1:0]        lk_pl1,
    output logic [1:0]        lk_pl2,
    output logic              lk_u,
    output logic [30:0]       lk_aid
);
    localparam logic [SLOT_W-1:0] FIRST_FREE = SLOT_W'(PINNED);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(ENTRIES - 1);

    // Entry store
    logic [ENTRIES-1:0]           vld_q;
    logic [ENTRIES-1:0][VA_W-1:0] start_q;
    logic [ENTRIES-1:0][VA_W-1:0] last_q;
    logic [ENTRIES-1:0][PA_W-1:0] pa_q;
    tlb_prot_t [ENTRIES-1:0]      prot_q;
    logic [SLOT_W-1:0]            rr_q;
    logic                         err_q;

    // Pending narrow insert
    logic            pend_vld;
    logic [VA_W-1:0] pend_lo, pend_hi;
    logic [PA_W-1:0] pend_pa;

    // Decoded command
    tlb_op_e         op;
    logic [VA_W-1:0] wide_lo, wide_hi, purge_lo, purge_hi, page_lo, page_hi, blk_hi;
    logic [PA_W-1:0] wide_pa, nar_pa, blk_pa;
    tlb_prot_t       wide_prot, nar_prot, blk_prot;

    // Control
    logic              fl_rng, fl_all, slot_ok, nar_ok, wr_en, rr_step, err_next;
    logic [VA_W-1:0]   fl_lo, fl_hi, new_lo, new_hi;
    logic [PA_W-1:0]   new_pa;
    tlb_prot_t         new_prot;
    logic [ENTRIES-1:0] kill, vld_after;
    logic [SLOT_W-1:0] victim, wr_slot;
    logic              use_rr;
    logic              hit;
    logic [SLOT_W-1:0] hit_idx;

    assign op = tlb_op_e'(cmd_op);

    vpt_cmd_decode #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)
    ) u_dec (
        .addr(cmd_addr), .w1(cmd_w1), .w2(cmd_w2), .len(cmd_len),
        .wide_lo(wide_lo), .wide_hi(wide_hi), .wide_pa(wide_pa), .wide_prot(wide_prot),
        .purge_lo(purge_lo), .purge_hi(purge_hi),
        .page_lo(page_lo), .page_hi(page_hi),
        .nar_pa(nar_pa), .nar_prot(nar_prot),
        .blk_hi(blk_hi), .blk_pa(blk_pa), .blk_prot(blk_prot)
    );

    // Select the flush range and the command's validity conditions.
    always_comb begin
        fl_rng  = 1'b0;
        fl_all  = cmd_valid && (op == OP_PURGE_ALL);
        fl_lo   = page_lo;
        fl_hi   = page_hi;
        slot_ok = ({1'b0, cmd_slot} < (SLOT_W + 1)'(PINNED));
        nar_ok  = pend_vld && (cmd_addr >= pend_lo) && (cmd_addr <= pend_hi);
        if (cmd_valid) begin
            case (op)
                OP_WIDE_INS:  begin fl_rng = 1'b1; fl_lo = wide_lo;  fl_hi = wide_hi;  end
                OP_NAR_ADDR:  begin fl_rng = 1'b1; fl_lo = page_lo;  fl_hi = page_hi;  end
                OP_PURGE_RNG: begin fl_rng = 1'b1; fl_lo = purge_lo; fl_hi = purge_hi; end
                default:      fl_rng = 1'b0;
            endcase
        end
    end

    vpt_overlap #(.ENTRIES(ENTRIES), .PINNED(PINNED), .VA_W(VA_W)) u_ovl (
        .rng_en(fl_rng), .all_en(fl_all), .rng_lo(fl_lo), .rng_hi(fl_hi),
        .vld(vld_q), .lo(start_q), .hi(last_q), .kill(kill)
    );

    assign vld_after = vld_q & ~kill;

    vpt_victim #(.ENTRIES(ENTRIES), .PINNED(PINNED), .IDX_W(SLOT_W)) u_vic (
        .vld(vld_after), .rr(rr_q), .slot(victim), .use_rr(use_rr)
    );

    // Choose what gets written, where, and whether the command errs.
    always_comb begin
        wr_en    = 1'b0;
        rr_step  = 1'b0;
        err_next = 1'b0;
        wr_slot  = victim;
        new_lo   = wide_lo;
        new_hi   = wide_hi;
        new_pa   = wide_pa;
        new_prot = wide_prot;
        if (cmd_valid) begin
            case (op)
                OP_WIDE_INS: begin
                    wr_en   = 1'b1;
                    rr_step = use_rr;
                end
                OP_NAR_PROT: begin
                    wr_en    = nar_ok;
                    rr_step  = nar_ok && use_rr;
                    err_next = !nar_ok;
                    new_lo   = pend_lo;
                    new_hi   = pend_hi;
                    new_pa   = pend_pa;
                    new_prot = nar_prot;
                end
                OP_BLK_INS: begin
                    wr_en    = slot_ok;
                    err_next = !slot_ok;
                    wr_slot  = cmd_slot;
                    new_lo   = page_lo;
                    new_hi   = blk_hi;
                    new_pa   = blk_pa;
                    new_prot = blk_prot;
                end
                OP_BLK_PURGE: err_next = !slot_ok;
                default: ;
            endcase
        end
    end

    // Update entry store, valid bits, error flag and replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= FIRST_FREE;
            err_q <= 1'b0;
        end else begin
            err_q <= err_next;
            vld_q <= vld_after;
            if (cmd_valid && (op == OP_BLK_PURGE) && slot_ok) begin
                vld_q[cmd_slot] <= 1'b0;
            end
            if (wr_en) begin
                vld_q[wr_slot]   <= 1'b1;
                start_q[wr_slot] <= new_lo;
                last_q[wr_slot]  <= new_hi;
                pa_q[wr_slot]    <= new_pa;
                prot_q[wr_slot]  <= new_prot;
            end
            if (fl_all) begin
                rr_q <= FIRST_FREE;
            end else if (rr_step) begin
                rr_q <= (rr_q == LAST_SLOT) ? FIRST_FREE : rr_q + SLOT_W'(1);
            end
        end
    end

    // Track the pending narrow insert between its two steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
        end else if (cmd_valid) begin
            if (op == OP_NAR_ADDR) begin
                pend_vld <= 1'b1;
                pend_lo  <= page_lo;
                pend_hi  <= page_hi;
                pend_pa  <= nar_pa;
            end else if ((op == OP_NAR_PROT) || (op == OP_PURGE_ALL)) begin
                pend_vld <= 1'b0;
            end
        end
    end

    vpt_lookup #(.ENTRIES(ENTRIES), .VA_W(VA_W), .IDX_W(SLOT_W)) u_lk (
        .va(lk_va), .vld(vld_q), .lo(start_q), .hi(last_q), .hit(hit), .idx(hit_idx)
    );

    // Drive lookup outputs from the winning entry, zero on a miss.
    always_comb begin
        lk_hit   = hit;
        lk_start = '0;
        lk_pa    = '0;
        {lk_t, lk_d, lk_b, lk_rtype, lk_pl1, lk_pl2, lk_u, lk_aid} = '0;
        if (hit) begin
            lk_start = start_q[hit_idx];
            lk_pa    = pa_q[hit_idx] + PA_W'(lk_va - start_q[hit_idx]);
            lk_t     = prot_q[hit_idx].t;
            lk_d     = prot_q[hit_idx].d;
            lk_b     = prot_q[hit_idx].b;
            lk_rtype = prot_q[hit_idx].rtype;
            lk_pl1   = prot_q[hit_idx].pl1;
            lk_pl2   = prot_q[hit_idx].pl2;
            lk_u     = prot_q[hit_idx].u;
            lk_aid   = prot_q[hit_idx].aid;
        end
    end

    assign cmd_err = err_q;
endmodule

// File: rtl/vpt_chk.sv
// Property checker for vpsize_tlb, attached by bind below.
// Observes ports plus the valid vector and replacement pointer.
module vpt_chk
    import vpt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PINNED  = 4,
    parameter int VA_W    = 48,
    parameter int SLOT_W  = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [SLOT_W-1:0] cmd_slot,
    input logic              cmd_err,
    input logic [VA_W-1:0]   lk_va,
    input logic              lk_hit,
    input logic [VA_W-1:0]   lk_start,
    input logic [ENTRIES-1:0] vld,
    input logic [SLOT_W-1:0] rr
);
    localparam logic [ENTRIES-1:0] FREE_MASK = ~((ENTRIES)'((64'd1 << PINNED) - 64'd1));

    // R1: a reported hit never starts above the looked-up address.
    p_hit_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_va >= lk_start));

    // R5: the round-robin pointer stays inside the non-pinned group.
    p_rr_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rr >= SLOT_W'(PINNED)) && ({1'b0, rr} < (SLOT_W + 1)'(ENTRIES)));

    // R6, R4: ordinary purges and inserts leave pinned valid bits alone.
    p_pinned_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op inside {3'd1, 3'd2, 3'd4, 3'd5}))
        |=> (vld[PINNED-1:0] == $past(vld[PINNED-1:0])));

    // R7: purge-all leaves no non-pinned entry valid.
    p_purge_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd5)) |=> ((vld & FREE_MASK) == '0));

    // R9: an out-of-range block slot raises the error flag.
    p_bad_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op inside {3'd6, 3'd7}) && ({1'b0, cmd_slot} >= (SLOT_W + 1)'(PINNED)))
        |=> cmd_err);

    // R10: the error flag only follows a command.
    p_err_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid));
endmodule

bind vpsize_tlb vpt_chk #(
    .ENTRIES(ENTRIES), .PINNED(PINNED), .VA_W(VA_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_slot(cmd_slot), .cmd_err(cmd_err), .lk_va(lk_va), .lk_hit(lk_hit),
    .lk_start(lk_start), .vld(vld_q), .rr(rr_q)
);

// File: tb/vpsize_tlb_test.sv
`timescale 1ns/1ps
module vpsize_tlb_test;
    localparam int VA_W = 48;
    localparam int PA_W = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [VA_W-1:0]   cmd_addr = '0;
    logic [63:0]       cmd_w1 = '0, cmd_w2 = '0;
    logic [3:0]        cmd_slot = '0;
    logic [15:0]       cmd_len = '0;
    logic              cmd_err;
    logic [VA_W-1:0]   lk_va = '0;
    logic              lk_hit, lk_t, lk_d, lk_b, lk_u;
    logic [VA_W-1:0]   lk_start;
    logic [PA_W-1:0]   lk_pa;
    logic [2:0]        lk_rtype;
    logic [1:0]        lk_pl1, lk_pl2;
    logic [30:0]       lk_aid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vpsize_tlb uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_w1(cmd_w1), .cmd_w2(cmd_w2), .cmd_slot(cmd_slot),
        .cmd_len(cmd_len), .cmd_err(cmd_err), .lk_va(lk_va), .lk_hit(lk_hit),
        .lk_start(lk_start), .lk_pa(lk_pa), .lk_t(lk_t), .lk_d(lk_d), .lk_b(lk_b),
        .lk_rtype(lk_rtype), .lk_pl1(lk_pl1), .lk_pl2(lk_pl2), .lk_u(lk_u), .lk_aid(lk_aid)
    );

    typedef struct packed {
        logic [2:0]      op;
        logic [VA_W-1:0] addr;
        logic [63:0]     w1;
        logic [63:0]     w2;
        logic [3:0]      slot;
        logic [15:0]     len;
        logic [VA_W-1:0] va;
        logic            e_err;
        logic            e_hit;
        logic [PA_W-1:0] e_pa;
        logic [VA_W-1:0] e_start;
    } vec_t;

    // Command, lookup address and expected err/hit/pa/start after it.
    localparam vec_t VEC [16] = '{
        '{3'd1, 48'h1234_5678, 64'h15780, 64'h11C0_0000_0000_000A, 4'd0, 16'd0, 48'h1234_5678, 1'b0, 1'b1, 40'hAB_C678, 48'h1234_5000},
        '{3'd1, 48'h4000_7ABC, 64'h6002, 64'h1000_0000_0000_0000, 4'd0, 16'd0, 48'h4000_F00C, 1'b0, 1'b1, 40'h30_F00C, 48'h4000_0000},
        '{3'd0, 48'h0, 64'h0, 64'h0, 4'd0, 16'd0, 48'h4001_0000, 1'b0, 1'b0, 40'h0, 48'h0},
        '{3'd4, 48'h4000_8000, 64'h0, 64'h0, 4'd0, 16'd0, 48'h4000_F00C, 1'b0, 1'b0, 40'h0, 48'h0},
        '{3'd6, 48'h8000_0000, 64'h777, 64'h0, 4'd1, 16'd3, 48'h8000_2FF0, 1'b0, 1'b1, 40'h77_9FF0, 48'h8000_0000},
        '{3'd4, 48'h8000_0003, 64'h0, 64'h0, 4'd0, 16'd0, 48'h8000_1000, 1'b0, 1'b1, 40'h77_8000, 48'h8000_0000},
        '{3'd5, 48'h0, 64'h0, 64'h0, 4'd0, 16'd0, 48'h8000_0004, 1'b0, 1'b1, 40'h77_7004, 48'h8000_0000},
        '{3'd0, 48'h0, 64'h0, 64'h0, 4'd0, 16'd0, 48'h1234_5678, 1'b0, 1'b0, 40'h0, 48'h0},
        '{3'd6, 48'h9000_0000, 64'h1, 64'h0, 4'd4, 16'd1, 48'h8000_0004, 1'b1, 1'b1, 40'h77_7004, 48'h8000_0000},
        '{3'd7, 48'h0, 64'h0, 64'h0, 4'd1, 16'd0, 48'h8000_0004, 1'b0, 1'b0, 40'h0, 48'h0},
        '{3'd2, 48'h55_5123, 64'h1340, 64'h0, 4'd0, 16'd0, 48'h55_5123, 1'b0, 1'b0, 40'h0, 48'h0},
        '{3'd3, 48'h55_5FFF, 64'h0, 64'h1000_0000, 4'd0, 16'd0, 48'h55_5010, 1'b0, 1'b1, 40'h9_A010, 48'h55_5000},
        '{3'd3, 48'h55_5010, 64'h0, 64'h1000_0000, 4'd0, 16'd0, 48'h55_5010, 1'b1, 1'b1, 40'h9_A010, 48'h55_5000},
        '{3'd2, 48'h66_6000, 64'h400, 64'h0, 4'd0, 16'd0, 48'h66_6000, 1'b0, 1'b0, 40'h0, 48'h0},
        '{3'd3, 48'h66_7000, 64'h0, 64'h1000_0000, 4'd0, 16'd0, 48'h66_6000, 1'b1, 1'b0, 40'h0, 48'h0},
        '{3'd7, 48'h0, 64'h0, 64'h0, 4'd9, 16'd0, 48'h55_5010, 1'b1, 1'b1, 40'h9_A010, 48'h55_5000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one command; returns after the edge, with inputs idle again.
    task automatic issue(input logic [2:0] op, input logic [VA_W-1:0] addr,
                         input logic [63:0] w1, input logic [63:0] w2,
                         input logic [3:0] slot, input logic [15:0] len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        cmd_w1 = w1; cmd_w2 = w2; cmd_slot = slot; cmd_len = len;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        #1;
    endtask

    task automatic look(input logic [VA_W-1:0] va);
        lk_va = va;
        #1;
    endtask

    // Wide insert of one page (n=0) with a physical page number.
    task automatic wide_page(input logic [VA_W-1:0] va, input logic [63:0] ppn);
        issue(3'd1, va, ppn << 5, 64'h1000_0000_0000_0000, 4'd0, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        look(48'h1234_5678);
        check("R11 hit after reset", lk_hit, 0);
        check("R11 err after reset", cmd_err, 0);
        rst_n = 1'b1;
        issue(3'd3, 48'h0, 64'h0, 64'h0, 4'd0, 16'd0);
        check("R11 no pending after reset", cmd_err, 1);

        // Table walk: R1 R2 R6 R7 R8 R9
        foreach (VEC[i]) begin
            issue(VEC[i].op, VEC[i].addr, VEC[i].w1, VEC[i].w2, VEC[i].slot, VEC[i].len);
            check("R8/R9 err", cmd_err, VEC[i].e_err);
            look(VEC[i].va);
            check("R1 hit", lk_hit, VEC[i].e_hit);
            check("R1/R2 pa", lk_pa, VEC[i].e_pa);
            check("R1/R6 start", lk_start, VEC[i].e_start);
        end

        // R3: wide field positions
        issue(3'd5, 0, 0, 0, 0, 0);
        issue(3'd1, 48'h70_0000, 64'h0,
              (64'd1 << 61) | (64'd1 << 59) | (64'd5 << 56) | (64'd2 << 54) |
              (64'd1 << 52) | (64'd1 << 51) | (64'h1234567 << 1), 4'd0, 16'd0);
        look(48'h70_0000);
        check("R3 t", lk_t, 1);   check("R3 d", lk_d, 0);
        check("R3 b", lk_b, 1);   check("R3 rtype", lk_rtype, 5);
        check("R3 pl1", lk_pl1, 2); check("R3 pl2", lk_pl2, 1);
        check("R3 u", lk_u, 1);   check("R3 aid", lk_aid, 31'h1234567);

        // R10: lookup in the command cycle sees the old state
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 48'h90_0000;
        cmd_w1 = 64'h20 << 5; cmd_w2 = 64'h0; lk_va = 48'h90_0010;
        #1;
        check("R10 same-cycle miss", lk_hit, 0);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        #1;
        check("R10 hit next cycle", lk_hit, 1);
        check("R10 pa next cycle", lk_pa, 40'h2_0010);

        // R4: overlapping non-pinned entry replaced by a larger range
        wide_page(48'hA0_0000, 64'h11);
        issue(3'd1, 48'hA0_1000, (64'h40 << 5) | 64'd1, 64'h0, 4'd0, 16'd0);
        look(48'hA0_0010);
        check("R4 old page replaced", lk_pa, 40'h4_0010);
        look(48'hA0_2010);
        check("R4 n=1 start", lk_start, 48'hA0_0000);
        check("R4 n=1 pa", lk_pa, 40'h4_2010);

        // R4/R9/R1: pinned slot survives overlap and wins priority; T=0 D=1
        issue(3'd6, 48'hB0_0000, 64'h55, (64'd1 << 29) | (64'd3 << 24), 4'd0, 16'd1);
        wide_page(48'hB0_0000, 64'h66);
        look(48'hB0_0020);
        check("R4 pinned kept on insert", lk_pa, 40'h5_5020);
        check("R9 T forced 0", lk_t, 0);
        check("R9 D forced 1", lk_d, 1);
        check("R9 type", lk_rtype, 3);
        issue(3'd7, 0, 0, 0, 4'd0, 0);
        look(48'hB0_0020);
        check("R1 next match after block purge", lk_pa, 40'h6_6020);

        // R5/R7: free slots first, then round-robin, reset by purge-all
        issue(3'd5, 0, 0, 0, 0, 0);
        for (int k = 0; k < 12; k++) wide_page(48'hC0_0000 + 48'(k) * 48'h1000, 64'h100 + 64'(k));
        look(48'hCB_000 + 48'hC0_0000 - 48'hCB_000 + 48'hB000);
        check("R5 all twelve present", lk_pa, 40'h10B_000);
        wide_page(48'hD0_0000, 64'h200);
        look(48'hC0_0000); check("R5 first rr victim", lk_hit, 0);
        look(48'hC0_1000); check("R5 neighbour kept", lk_hit, 1);
        look(48'hD0_0000); check("R5 new entry", lk_pa, 40'h20_0000);
        wide_page(48'hD0_1000, 64'h201);
        look(48'hC0_1000); check("R5 second rr victim", lk_hit, 0);
        look(48'hC0_2000); check("R5 third kept", lk_hit, 1);
        issue(3'd5, 0, 0, 0, 0, 0);
        look(48'hD0_0000); check("R7 purge-all clears", lk_hit, 0);
        for (int k = 0; k < 12; k++) wide_page(48'hC0_0000 + 48'(k) * 48'h1000, 64'h100 + 64'(k));
        wide_page(48'hD0_0000, 64'h200);
        look(48'hC0_0000); check("R7 pointer reset victim", lk_hit, 0);
        look(48'hC0_2000); check("R7 pointer reset keeps slot 6", lk_hit, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule